// File: doc/BRIEF.md
# Power-Good Output Bank with Per-Channel Hold-Off

This block drives a bank of independent power-good outputs, one for each monitored supply rail. An external comparator reports for each rail whether it is below its threshold. The block passes that flag through a two-stage synchroniser. It pulls the matching output low (not good) as soon as the rail is low. The output returns high only after a fixed hold-off that starts once the rail has recovered. The outputs can drive the enable pins of downstream regulators, so that the rails come up one after another.

Three global controls act on every channel at once. An active-high disable input forces every output low. A lockout input reports that the block's own supply is too low, and it also holds every output low. An active-low margin input freezes every output and every hold-off counter at its present value while it is asserted. The hold-off is counted in pulses of a clock-enable tick, so a slow time base can set the real hold-off time.

Top module: `pg_bank`

## Requirements
- R1: A below-threshold flag on channel i pulls pg_ok[i] low. The change appears at the third rising clock edge after the flag changes: two edges for the synchroniser and one for the output register.
- R2: While pg_disable is 1, every pg_ok bit is 0 from the next rising edge on, unless the margin freeze is active.
- R3: After a channel's last fault clears, its pg_ok rises at exactly the HOLD_TICKS-th tick-qualified edge counted from the first fault-free evaluation. A fault is a synchronised low flag, pg_disable or lockout.
- R4: If a channel's flag dips low again before its hold-off expires, the hold-off count restarts from zero.
- R5: The hold-off count advances only on edges where tick is 1. With tick held at 0, a recovering output stays low indefinitely.
- R6: While margin_n is 0 and uvlo is 0, every pg_ok bit keeps its value, whatever below_thr and pg_disable do.
- R7: When margin_n returns to 1, each channel continues its hold-off from the count it had when frozen.
- R8: While uvlo is 1, every pg_ok bit is 0 from the next edge on. This takes priority over the margin freeze, and the counters clear.
- R9: pg_ok[i] depends only on below_thr[i] and the global controls. Every mix of low rails gives pg_ok equal to the bitwise inverse of the flag pattern.
- R10: During reset every pg_ok bit is 0 and every counter is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| below_thr | input | NUM_CH | Per-rail below-threshold flags, asynchronous |
| pg_disable | input | 1 | 1 forces every output low |
| uvlo | input | 1 | 1 while the block supply is in lockout |
| margin_n | input | 1 | 0 freezes every output and counter |
| tick | input | 1 | Clock enable for the hold-off count |
| pg_ok | output | NUM_CH | Per-rail power-good, 1 = good |

## Verification
A flag change on below_thr reaches pg_ok at the third edge. A change on pg_disable, uvlo or margin_n acts at the very next edge. A release lands HOLD_TICKS tick-edges after the first fault-free evaluation, which is two edges later for a flag and zero edges later for a global control. The bench drives inputs and samples outputs at the falling edge. Each timing check is made twice: one cycle before the due edge, where the old value must still hold, and exactly at the due edge. An early or late change is therefore caught either way. All fifteen nonzero flag patterns on four channels are swept, and the freeze, resume, restart and tick-gating cases use cycle counts worked out from these latencies.

// File: rtl/pg_bank_pkg.sv
package pg_bank_pkg;

  typedef enum logic [1:0] {
    ACT_CLEAR  = 2'd0,
    ACT_FREEZE = 2'd1,
    ACT_FAULT  = 2'd2,
    ACT_COUNT  = 2'd3
  } pg_action_e;

  // Counter width needed to count 0 .. hold-1
  function automatic int unsigned cnt_width(input int unsigned hold);
    return (hold > 1) ? $clog2(hold) : 1;
  endfunction

  // True when the count has reached its last step
  function automatic logic hold_expired(input logic [31:0] cnt, input int unsigned hold);
    return cnt == (hold - 1);
  endfunction

  // Priority: lockout over freeze over fault over counting
  function automatic pg_action_e pick_action(input logic lockout, input logic freeze,
                                             input logic fault);
    if (lockout)     return ACT_CLEAR;
    else if (freeze) return ACT_FREEZE;
    else if (fault)  return ACT_FAULT;
    else             return ACT_COUNT;
  endfunction

endpackage

// File: rtl/pg_sync2.sv
module pg_sync2 #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/pg_channel.sv
module pg_channel
  import pg_bank_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 8,
  parameter int unsigned CW         = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic freeze,
  input  logic lockout,
  input  logic tick,
  output logic pg_ok,
  output logic rel_evt
);
  logic          pg_q;
  logic [CW-1:0] cnt_q;
  pg_action_e    act;
  logic          at_end;

  assign act     = pick_action(lockout, freeze, fault);
  assign at_end  = hold_expired(32'(cnt_q), HOLD_TICKS);
  assign rel_evt = (act == ACT_COUNT) && !pg_q && tick && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      unique case (act)
        ACT_CLEAR, ACT_FAULT: begin
          pg_q  <= 1'b0;
          cnt_q <= '0;
        end
        ACT_FREEZE: begin
          pg_q  <= pg_q;
          cnt_q <= cnt_q;
        end
        ACT_COUNT: begin
          if (!pg_q && tick) begin
            if (at_end) begin
              pg_q  <= 1'b1;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
        end
      endcase
    end
  end

  assign pg_ok = pg_q;
endmodule

// File: rtl/pg_bank.sv
module pg_bank
  import pg_bank_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned HOLD_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] below_thr,
  input  logic              pg_disable,
  input  logic              uvlo,
  input  logic              margin_n,
  input  logic              tick,
  output logic [NUM_CH-1:0] pg_ok
);
  localparam int unsigned CW = cnt_width(HOLD_TICKS);

  logic [NUM_CH-1:0] below_sync;
  logic [NUM_CH-1:0] chan_fault;
  logic [NUM_CH-1:0] rel_evt;
  logic              freeze_all;

  pg_sync2 #(.WIDTH(NUM_CH)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (below_thr),
    .q    (below_sync)
  );

  assign freeze_all = !margin_n;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign chan_fault[i] = below_sync[i] | pg_disable;

    pg_channel #(.HOLD_TICKS(HOLD_TICKS), .CW(CW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .fault  (chan_fault[i]),
      .freeze (freeze_all),
      .lockout(uvlo),
      .tick   (tick),
      .pg_ok  (pg_ok[i]),
      .rel_evt(rel_evt[i])
    );
  end
endmodule

// File: rtl/pg_bank_checker.sv
module pg_bank_checker #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pg_disable,
  input logic              uvlo,
  input logic              margin_n,
  input logic [NUM_CH-1:0] below_sync,
  input logic [NUM_CH-1:0] rel_evt,
  input logic [NUM_CH-1:0] pg_ok
);
  // R1: a synchronised low rail drops its own output next edge
  p_rail_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((below_sync != '0) && margin_n && !uvlo) |=> ((pg_ok & $past(below_sync)) == '0));

  // R2: disable forces every output low
  p_disable_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_disable && margin_n && !uvlo) |=> (pg_ok == '0));

  // R3: an output rises only where its hold-off ended on the previous edge
  p_rise_on_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pg_ok & ~$past(pg_ok) & ~$past(rel_evt)) == '0));

  // R6: margin freezes every output
  p_margin_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!margin_n && !uvlo) |=> (pg_ok == $past(pg_ok)));

  // R8: lockout forces every output low, even under margin
  p_lockout_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (pg_ok == '0));
endmodule

bind pg_bank pg_bank_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pg_disable(pg_disable),
  .uvlo      (uvlo),
  .margin_n  (margin_n),
  .below_sync(below_sync),
  .rel_evt   (rel_evt),
  .pg_ok     (pg_ok)
);

// File: tb/tb_pg_bank.sv
`timescale 1ns/1ps
module tb_pg_bank;
  localparam int N    = 4;
  localparam int HOLD = 8;
  localparam logic [N-1:0] ALL = '1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] below_thr;
  logic         pg_disable;
  logic         uvlo;
  logic         margin_n;
  logic         tick;
  logic [N-1:0] pg_ok;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  pg_bank #(.NUM_CH(N), .HOLD_TICKS(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .below_thr(below_thr), .pg_disable(pg_disable),
    .uvlo(uvlo), .margin_n(margin_n), .tick(tick), .pg_ok(pg_ok)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [N-1:0] exp);
    checks++;
    if (pg_ok !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, pg_ok, exp);
    end
  endtask

  initial begin
    rst_n = 0; below_thr = '0; pg_disable = 0; uvlo = 0; margin_n = 1; tick = 1;
    step(3);
    chk("R10 reset low", '0);
    rst_n = 1;
    step(HOLD - 1); chk("R10 no early release", '0);
    step(1);        chk("R3 release after reset", ALL);

    // R1/R9/R3: sweep every nonzero pattern of low rails
    for (int m = 1; m < (1 << N); m++) begin
      below_thr = N'(m);
      step(2); chk("R1 sync latency", ALL);
      step(1); chk("R9 pattern", ~N'(m));
      below_thr = '0;
      step(HOLD + 1); chk("R3 still held", ~N'(m));
      step(1);        chk("R3 release", ALL);
    end

    // R2: disable input
    pg_disable = 1;
    step(1); chk("R2 forced low", '0);
    step(5); chk("R2 stays low", '0);
    pg_disable = 0;
    step(HOLD - 1); chk("R2 held after release", '0);
    step(1);        chk("R2 released", ALL);

    // R4: dip during hold-off restarts the count
    below_thr = 4'b0001; step(3);
    below_thr = '0;      step(5);
    below_thr = 4'b0001; step(1);
    below_thr = '0;
    step(HOLD + 1); chk("R4 restarted", 4'b1110);
    step(1);        chk("R4 release", ALL);

    // R5: tick gating
    tick = 0;
    below_thr = 4'b0010; step(3);
    below_thr = '0;      step(20);
    chk("R5 no tick no count", 4'b1101);
    for (int k = 0; k < HOLD - 1; k++) begin
      tick = 1; step(1); tick = 0; step(2);
    end
    chk("R5 one tick short", 4'b1101);
    tick = 1; step(1); tick = 0;
    chk("R5 released on last tick", ALL);
    tick = 1;

    // R6: freeze a mixed state
    below_thr = 4'b0011; step(3);
    chk("R6 setup", 4'b1100);
    margin_n = 0;
    below_thr = '0;
    step(HOLD + 10); chk("R6 low held", 4'b1100);
    below_thr = 4'b1100; pg_disable = 1;
    step(5); chk("R6 high held", 4'b1100);
    below_thr = '0; pg_disable = 0;
    step(3);
    margin_n = 1;
    step(HOLD - 1); chk("R6 counting after thaw", 4'b1100);
    step(1);        chk("R6 released", ALL);

    // R7: resume mid-count
    pg_disable = 1; step(1);
    pg_disable = 0; step(3);
    margin_n = 0;   step(20);
    margin_n = 1;
    step(HOLD - 4); chk("R7 resume low", '0);
    step(1);        chk("R7 resume release", ALL);

    // R8: lockout wins over margin
    margin_n = 0; uvlo = 1;
    step(1); chk("R8 lockout over margin", '0);
    margin_n = 1;
    step(5); chk("R8 lockout held", '0);
    uvlo = 0;
    step(HOLD - 1); chk("R8 held after lockout", '0);
    step(1);        chk("R8 released", ALL);

    finish_run();
  end
endmodule